// File: doc/BRIEF.md
# Transaction ID Mask Filter with Byte Accumulation

This block sits beside a performance counter bank and decides which memory read and write transactions count as ID-filtered events. One shared 32-bit filter register holds a reference transaction ID and a compare mask. Every read strobe and every write strobe carries a 16-bit transaction ID. The block compares that ID with the reference under the mask. A hit raises a one-cycle read-match or write-match pulse, and the counter bank counts these pulses when a counter selects event code 0x41 (filtered reads) or 0x42 (filtered writes).

The mask held in the register is active-high: a set bit means that ID bit is compared. Software keeps the user-facing mask active-low and inverts it before writing. All counters share this one filter setting.

When the `ENHANCED` parameter is set, the block also keeps a byte total for each counter. A counter that is enabled and selects code 0x41 or 0x42 adds the byte count of every matching transaction of its direction. Software reads these totals in place of burst counts. A counter's total is cleared together with that counter's clear strobe. Writing the filter register does not clear the totals.

Top module: `txid_filter_counter`

## Requirements
- R1: After reset the filter register reads 0, so every valid transaction matches, and every byte total reads 0.
- R2: The filter register holds the reference ID in bits [15:0] and the stored compare mask in bits [31:16]. A transaction matches when ((id XOR reference) AND stored mask) is 0, so a mask bit of 1 means that ID bit is compared.
- R3: `rd_match` is high in the same cycle as `rd_valid` when the read ID matches, and it is never high without `rd_valid`.
- R4: `wr_match` works the same way from `wr_valid` and `wr_id`, independently of the read channel.
- R5: A filter write takes effect in the cycle after `cfg_we`. A transaction in the write cycle itself is judged against the old setting.
- R6: In the enhanced mode, an enabled counter whose code is 0x41 adds `rd_bytes` on each read match, and one whose code is 0x42 adds `wr_bytes` on each write match. The new total is visible one cycle after the strobe.
- R7: A counter whose code is neither 0x41 nor 0x42 never changes its byte total.
- R8: Writing the filter register leaves every byte total unchanged.
- R9: `cnt_clr[n]` sets total n to 0 in the next cycle and takes priority over an add in the same cycle.
- R10: A counter whose `cnt_en` bit is low holds its byte total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Filter register write strobe |
| cfg_wdata | input | 32 | Filter value: mask [31:16], reference ID [15:0] |
| rd_valid | input | 1 | Read transaction strobe |
| rd_id | input | 16 | Read transaction ID |
| rd_bytes | input | BYTE_W | Read transaction byte count |
| wr_valid | input | 1 | Write transaction strobe |
| wr_id | input | 16 | Write transaction ID |
| wr_bytes | input | BYTE_W | Write transaction byte count |
| cnt_code | input | NCNT*8 | Event code of each counter, counter n in bits [8n+7:8n] |
| cnt_en | input | NCNT | Enable of each counter |
| cnt_clr | input | NCNT | Clear strobe of each counter |
| filt_o | output | 32 | Current filter register |
| rd_match | output | 1 | Filtered read event pulse |
| wr_match | output | 1 | Filtered write event pulse |
| byte_total | output | NCNT*TOT_W | Byte totals, counter n in bits [TOT_W*(n+1)-1:TOT_W*n] |

## Verification
The match pulses are combinational, so they are due in the same cycle as the strobe. The bench drives inputs at the falling edge and compares them shortly afterwards against the model's current filter value. Filter writes and byte totals are due one rising edge later. The model applies each cycle's inputs to its own state at the rising edge, and the next comparison is made after the following falling edge. This keeps model and design aligned on every cycle, including the cycle in which a filter write and a transaction coincide, and the cycle in which a clear and an add coincide.

// File: rtl/txf_pkg.sv
// Shared constants and the masked-compare function for the ID filter.
package txf_pkg;
    localparam int ID_W = 16;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] EVT_RD_FILT = 8'h41;
    localparam logic [CODE_W-1:0] EVT_WR_FILT = 8'h42;

    // True when every compared bit (mask=1) of id equals the reference.
    function automatic logic id_hit(input logic [ID_W-1:0] id,
                                    input logic [ID_W-1:0] ref_id,
                                    input logic [ID_W-1:0] keep);
        return ((id ^ ref_id) & keep) == '0;
    endfunction
endpackage

// File: rtl/txf_matcher.sv
// Masked ID matcher for one transaction channel.
// Assumes the filter value is stable during the cycle; output is combinational.
module txf_matcher
    import txf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] ref_id,
    input  logic [ID_W-1:0] keep,
    output logic            hit
);
    // Qualify the masked compare with the channel strobe.
    always_comb begin
        hit = valid && id_hit(id, ref_id, keep);
    end

    // R3: a match pulse only ever comes with its strobe.
    assert_pulse_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> valid);
endmodule

// File: rtl/txf_byte_acc.sv
// Byte total for one counter. Adds bytes of matching transactions in the
// direction its event code selects, when enabled. Clear wins over add.
module txf_byte_acc
    import txf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [BYTE_W-1:0] rd_bytes,
    input  logic [BYTE_W-1:0] wr_bytes,
    output logic [TOT_W-1:0]  total
);
    logic [TOT_W-1:0] add_val;

    // Pick the byte count to add this cycle, zero when nothing qualifies.
    always_comb begin
        add_val = '0;
        if (en && code == EVT_RD_FILT && rd_hit) add_val = TOT_W'(rd_bytes);
        else if (en && code == EVT_WR_FILT && wr_hit) add_val = TOT_W'(wr_bytes);
    end

    // Hold, clear or accumulate the total.
    always_ff @(posedge clk) begin
        if (!rst_n)   total <= '0;
        else if (clr) total <= '0;
        else          total <= total + add_val;
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> total == '0);
    assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(total));
    assert_other_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code != EVT_RD_FILT && code != EVT_WR_FILT && !clr) |=> $stable(total));
endmodule

// File: rtl/txid_filter_counter.sv
// Transaction ID mask filter: one shared filter register, read and write
// match pulses, and, when ENHANCED is set, per-counter byte totals.
// Assumes software writes the compare mask already inverted (1 = compare).
module txid_filter_counter
    import txf_pkg::*;
#(
    parameter int NCNT     = 4,
    parameter int BYTE_W   = 8,
    parameter int TOT_W    = 32,
    parameter bit ENHANCED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2*ID_W-1:0]      cfg_wdata,
    input  logic                   rd_valid,
    input  logic [ID_W-1:0]        rd_id,
    input  logic [BYTE_W-1:0]      rd_bytes,
    input  logic                   wr_valid,
    input  logic [ID_W-1:0]        wr_id,
    input  logic [BYTE_W-1:0]      wr_bytes,
    input  logic [NCNT*CODE_W-1:0] cnt_code,
    input  logic [NCNT-1:0]        cnt_en,
    input  logic [NCNT-1:0]        cnt_clr,
    output logic [2*ID_W-1:0]      filt_o,
    output logic                   rd_match,
    output logic                   wr_match,
    output logic [NCNT*TOT_W-1:0]  byte_total
);
    logic [2*ID_W-1:0] filt_q;
    logic [ID_W-1:0]   ref_id;
    logic [ID_W-1:0]   keep;

    // Shared filter register; writes land at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      filt_q <= '0;
        else if (cfg_we) filt_q <= cfg_wdata;
    end

    assign ref_id = filt_q[ID_W-1:0];
    assign keep   = filt_q[2*ID_W-1:ID_W];
    assign filt_o = filt_q;

    txf_matcher u_rd_match (
        .clk(clk), .rst_n(rst_n), .valid(rd_valid), .id(rd_id),
        .ref_id(ref_id), .keep(keep), .hit(rd_match)
    );

    txf_matcher u_wr_match (
        .clk(clk), .rst_n(rst_n), .valid(wr_valid), .id(wr_id),
        .ref_id(ref_id), .keep(keep), .hit(wr_match)
    );

    generate
        if (ENHANCED) begin : g_bytes
            for (genvar n = 0; n < NCNT; n++) begin : g_acc
                txf_byte_acc #(.BYTE_W(BYTE_W), .TOT_W(TOT_W)) u_acc (
                    .clk(clk), .rst_n(rst_n), .en(cnt_en[n]), .clr(cnt_clr[n]),
                    .code(cnt_code[n*CODE_W +: CODE_W]),
                    .rd_hit(rd_match), .wr_hit(wr_match),
                    .rd_bytes(rd_bytes), .wr_bytes(wr_bytes),
                    .total(byte_total[n*TOT_W +: TOT_W])
                );
            end
        end else begin : g_no_bytes
            assign byte_total = '0;
        end
    endgenerate

    assert_cfg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> filt_q == $past(cfg_wdata));
    assert_filter_write_keeps_totals_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !rd_valid && !wr_valid && cnt_clr == '0) |=> $stable(byte_total));
endmodule

// File: tb/txid_filter_counter_test.sv
// Bench for txid_filter_counter with a behavioural model checked every cycle.
module txid_filter_counter_test;
    localparam int N = 4;
    localparam int TW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic rd_valid = 1'b0, wr_valid = 1'b0;
    logic [15:0] rd_id = '0, wr_id = '0;
    logic [7:0] rd_bytes = '0, wr_bytes = '0;
    logic [N*8-1:0] cnt_code = '0;
    logic [N-1:0] cnt_en = '0, cnt_clr = '0;
    logic [31:0] filt_o;
    logic rd_match, wr_match;
    logic [N*TW-1:0] byte_total;

    always #2.5 clk = ~clk;

    txid_filter_counter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_bytes(rd_bytes),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_bytes(wr_bytes),
        .cnt_code(cnt_code), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
        .filt_o(filt_o), .rd_match(rd_match), .wr_match(wr_match),
        .byte_total(byte_total)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    bit [31:0] m_filt = 0;
    longint unsigned m_tot[N];
    string tag_m = "R3", tag_t = "R6";

    task automatic check(string tag, longint unsigned act, longint unsigned exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_hit(bit v, bit [15:0] id);
        return v && (((id ^ m_filt[15:0]) & m_filt[31:16]) == 0);
    endfunction

    // Compare all outputs with the model, then advance both by one clock.
    task automatic step;
        bit rh, wh;
        #1;
        rh = m_hit(rd_valid, rd_id);
        wh = m_hit(wr_valid, wr_id);
        check(tag_m, rd_match, rh, "rd_match");
        check(tag_m == "R3" ? "R4" : tag_m, wr_match, wh, "wr_match");
        check("R5", filt_o, m_filt, "filter");
        for (int n = 0; n < N; n++)
            check(tag_t, byte_total[n*TW +: TW], m_tot[n], "byte total");
        @(posedge clk);
        if (rst_n) begin
            for (int n = 0; n < N; n++) begin
                if (cnt_clr[n]) m_tot[n] = 0;
                else if (cnt_en[n] && cnt_code[n*8 +: 8] == 8'h41 && rh)
                    m_tot[n] = (m_tot[n] + rd_bytes) & 32'hFFFFFFFF;
                else if (cnt_en[n] && cnt_code[n*8 +: 8] == 8'h42 && wh)
                    m_tot[n] = (m_tot[n] + wr_bytes) & 32'hFFFFFFFF;
            end
            if (cfg_we) m_filt = cfg_wdata;
        end
        @(negedge clk);
        cfg_we = 0; rd_valid = 0; wr_valid = 0; cnt_clr = '0;
    endtask

    task automatic rd(bit [15:0] id, bit [7:0] b);
        rd_valid = 1; rd_id = id; rd_bytes = b;
    endtask
    task automatic wr(bit [15:0] id, bit [7:0] b);
        wr_valid = 1; wr_id = id; wr_bytes = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit [15:0] lf = 16'hACE1;
        for (int n = 0; n < N; n++) m_tot[n] = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: reset state, all-zero filter matches anything.
        tag_m = "R1"; tag_t = "R1";
        check("R1", filt_o, 0, "reset filter");
        rd(16'hBEEF, 8'd3); wr(16'h0001, 8'd4); step;
        // counters: 0 reads, 1 writes, 2 reads (toggled), 3 other code.
        cnt_code = {8'h05, 8'h41, 8'h42, 8'h41};
        cnt_en = 4'b1111;
        tag_t = "R6"; tag_m = "R3";
        rd(16'h0010, 8'd5); wr(16'h0020, 8'd7); step;
        // R2: compare upper byte only, reference 0x12xx.
        tag_m = "R2";
        cfg_we = 1; cfg_wdata = {16'hFF00, 16'h1234};
        rd(16'h5555, 8'd9); // R5: still judged against the old filter
        tag_t = "R5"; step;
        tag_t = "R6";
        rd(16'h12AB, 8'd11); wr(16'h13AB, 8'd13); step;
        rd(16'h1300, 8'd2); wr(16'h12FF, 8'd6); step;
        // R8: rewrite filter, totals unchanged.
        tag_t = "R8";
        cfg_we = 1; cfg_wdata = {16'hFFFF, 16'h0042}; step;
        step;
        tag_m = "R2"; tag_t = "R6";
        rd(16'h0042, 8'd20); wr(16'h0043, 8'd21); step;
        // R10: disable counter 2.
        tag_t = "R10"; cnt_en[2] = 0;
        rd(16'h0042, 8'd30); step; step;
        cnt_en[2] = 1;
        // R9: clear with simultaneous add.
        tag_t = "R9";
        cnt_clr = 4'b0001; rd(16'h0042, 8'd40); step; step;
        // R7: counter 3 with other code never moves.
        tag_t = "R7";
        check("R7", byte_total[3*TW +: TW], 0, "other-code total");
        // Mixed traffic, both channels.
        tag_m = "R3"; tag_t = "R6";
        cfg_we = 1; cfg_wdata = {16'h00F0, 16'h0030}; step;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rd_valid = lf[0]; rd_id = {lf[7:0], lf[15:8]}; rd_bytes = lf[15:8];
            wr_valid = lf[1]; wr_id = lf ^ 16'h3C3C; wr_bytes = lf[7:0];
            cnt_clr = (lf[6:2] == 0) ? 4'b0010 : 4'b0000;
            cnt_en[2] = lf[9];
            if (i == 150) begin cfg_we = 1; cfg_wdata = {16'h0000, 16'h0}; end
            step;
        end
        check("R7", byte_total[3*TW +: TW], 0, "other-code total end");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule